// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write an external asynchronous static RAM of 32K words by 8 bits. The system side issues one access at a time with a request strobe, a direction bit, an address and write data. It receives read data with a one-cycle valid pulse, and a busy flag that covers the whole access. The memory side drives the active-low select, write strobe and output enable, a registered address, and a shared data bus. The bus is split into a driven value, a driver enable and a sampled input.

Each timing window of the memory is a nanosecond parameter. It is turned into whole clock cycles from the clock period, so one build can match any speed grade: read cycle, access time, output enable to valid, write cycle, address to end of write, write pulse, data setup, address setup, recovery and hold. Output enable stays high for the whole of every write, and select falls no later than the write strobe. As a result, the memory's drivers are never on while the controller drives the bus. When the direction of access changes, an idle turnaround period with the driver off is inserted. Between accesses the memory is deselected, which is its low-power standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, busy is 0 and rd_valid is 0.
- R2: Whenever busy is 0, mem_cs_n and mem_we_n are 1 and mem_dq_oe is 0 (standby, bus released).
- R3: A read (req_we = 0) holds mem_cs_n and mem_oe_n at 0 with mem_we_n at 1 for RD_CYC cycles. RD_CYC = max(ceil(tAA/T), ceil(tRC/T), ceil(tOE/T), 1), where T is the clock period. The word on mem_dq_in at the end of that window is then returned on rd_data, together with a one-cycle rd_valid pulse.
- R4: During a write (req_we = 1), mem_oe_n stays 1. mem_cs_n is 0 in every cycle in which mem_we_n is 0, and the memory word at the address receives req_wdata.
- R5: mem_we_n is 0 for exactly WP_CYC consecutive cycles per write. WP_CYC = max(ceil(tWP/T), ceil(tDW/T), ceil(tAW/T) - AS_CYC, 1), where AS_CYC = ceil(tAS/T).
- R6: mem_dq_oe is 1 in every cycle in which mem_we_n is 0. Address and data do not change during the pulse, and mem_dq_oe is still 1 in the cycle after mem_we_n rises.
- R7: When an access has the opposite direction to the previous one, TURN_CYC (at least 1) extra cycles with mem_cs_n = 1 and mem_dq_oe = 0 come before it. Same-direction accesses get none, and neither does the first access after reset.
- R8: mem_dq_oe is never 1 while mem_cs_n = 0, mem_oe_n = 0 and mem_we_n = 1.
- R9: A request sampled while busy is 0 raises busy on the next cycle. Busy stays high for exactly the access length: RD_CYC for a read, or AS_CYC + WP_CYC + HOLD_CYC for a write, plus TURN_CYC on a direction change. HOLD_CYC = max(1, ceil(tWR/T), ceil(tDH/T), ceil(tWC/T) - AS_CYC - WP_CYC). A request while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled when busy is 0 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| busy | output | 1 | High from acceptance to completion |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 8 | Value sampled from the data bus |

## Verification
A sequencer stuck in a wrong state or a mis-loaded cycle counter shows up first in the length of busy. A wrong length is visible on the very access where it happens. A read captured one cycle early returns the bus filler value instead of stored data, so the scoreboard flags it on the rd_valid pulse of that same read. A lost or stretched write pulse, a driver that stays on into a read, or a missing turnaround period shows up within one cycle on the memory pins. It is also caught later, when the word written is read back wrong.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TURN = 3'd1,
    ST_RD   = 3'd2,
    ST_WSET = 3'd3,
    ST_WPUL = 3'd4,
    ST_WHLD = 3'd5
  } sram_st_e;

  // round a window in ns up to whole clock periods
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    if (ns <= 0) return 0;
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int RD_CYC   = 1,
  parameter int AS_CYC   = 0,
  parameter int WP_CYC   = 1,
  parameter int HOLD_CYC = 1,
  parameter int TA_CYC   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_we,
  input  logic             cnt_expired,
  output sram_st_e         state,
  output sram_st_e         nxt,
  output logic             accept,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val
);
  logic pend_we;
  logic last_wr;
  logic have_last;
  logic start_we;
  logic need_turn;

  assign accept    = (state == ST_IDLE) && req;
  assign start_we  = (state == ST_IDLE) ? req_we : pend_we;
  assign need_turn = have_last && (last_wr != req_we);

  always_comb begin
    nxt      = state;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (state)
      ST_IDLE: begin
        if (req) begin
          cnt_load = 1'b1;
          if (need_turn) begin
            nxt     = ST_TURN;
            cnt_val = CNT_W'(TA_CYC - 1);
          end else if (!start_we) begin
            nxt     = ST_RD;
            cnt_val = CNT_W'(RD_CYC - 1);
          end else if (AS_CYC > 0) begin
            nxt     = ST_WSET;
            cnt_val = CNT_W'(imax(AS_CYC - 1, 0));
          end else begin
            nxt     = ST_WPUL;
            cnt_val = CNT_W'(WP_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (cnt_expired) begin
          cnt_load = 1'b1;
          if (!start_we) begin
            nxt     = ST_RD;
            cnt_val = CNT_W'(RD_CYC - 1);
          end else if (AS_CYC > 0) begin
            nxt     = ST_WSET;
            cnt_val = CNT_W'(imax(AS_CYC - 1, 0));
          end else begin
            nxt     = ST_WPUL;
            cnt_val = CNT_W'(WP_CYC - 1);
          end
        end
      end
      ST_RD: begin
        if (cnt_expired) nxt = ST_IDLE;
      end
      ST_WSET: begin
        if (cnt_expired) begin
          nxt      = ST_WPUL;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WPUL: begin
        if (cnt_expired) begin
          nxt      = ST_WHLD;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_WHLD: begin
        if (cnt_expired) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend_we   <= 1'b0;
      last_wr   <= 1'b0;
      have_last <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        pend_we   <= req_we;
        last_wr   <= req_we;
        have_last <= 1'b1;
      end
    end
  end

  // R7: a turnaround period is entered only from idle, never mid-access
  a_r7_turn_from_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TURN) && ($past(state) != ST_TURN) |-> $past(state) == ST_IDLE);
endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sram_st_e          state,
  input  sram_st_e          nxt,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  logic rd_done;
  assign rd_done = (state == ST_RD) && (nxt == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      busy      <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      mem_cs_n  <= !(nxt inside {ST_RD, ST_WSET, ST_WPUL});
      mem_we_n  <= !(nxt == ST_WPUL);
      mem_oe_n  <= !(nxt == ST_RD);
      mem_dq_oe <= (nxt inside {ST_WSET, ST_WPUL, ST_WHLD});
      busy      <= (nxt != ST_IDLE);
      rd_valid  <= rd_done;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (rd_done) rd_data <= mem_dq_in;
    end
  end

  // R8: driver never fights the memory's read drivers
  a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n));
  // R4: output enable high and select low while the write strobe is low
  a_r4_strobe_qualified: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n));
  // R6: data driven during the pulse and still driven one cycle after it
  a_r6_drive_in_pulse: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);
  a_r6_hold_after_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe);
  a_r6_stable_in_pulse: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
  // R3: valid is a single-cycle pulse ending the access
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  a_r3_valid_ends_busy: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !busy && $past(busy));
  // R2: standby whenever not busy
  a_r2_standby: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mem_cs_n && mem_we_n && !mem_dq_oe));
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 15,
  parameter int T_AA_NS       = 15,
  parameter int T_OE_NS       = 7,
  parameter int T_WC_NS       = 15,
  parameter int T_AW_NS       = 10,
  parameter int T_WP_NS       = 10,
  parameter int T_DW_NS       = 7,
  parameter int T_AS_NS       = 0,
  parameter int T_WR_NS       = 0,
  parameter int T_DH_NS       = 0,
  parameter int TURN_CYC      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int P        = CLK_PERIOD_NS;
  localparam int RD_CYC   = imax(imax(ns_to_cyc(T_AA_NS, P), ns_to_cyc(T_RC_NS, P)),
                                 imax(ns_to_cyc(T_OE_NS, P), 1));
  localparam int AS_CYC   = ns_to_cyc(T_AS_NS, P);
  localparam int WP_CYC   = imax(imax(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_DW_NS, P)),
                                 imax(ns_to_cyc(T_AW_NS, P) - AS_CYC, 1));
  localparam int HOLD_CYC = imax(imax(ns_to_cyc(T_WR_NS, P), ns_to_cyc(T_DH_NS, P)),
                                 imax(ns_to_cyc(T_WC_NS, P) - AS_CYC - WP_CYC, 1));
  localparam int TA_CYC   = imax(TURN_CYC, 1);
  localparam int MAX_CYC  = imax(imax(RD_CYC, AS_CYC), imax(imax(WP_CYC, HOLD_CYC), TA_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  sram_st_e         state, nxt;
  logic             accept, cnt_load, cnt_expired;
  logic [CNT_W-1:0] cnt_val;

  sram_wait_cnt #(.CNT_W(CNT_W)) i_wait (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .expired(cnt_expired)
  );

  sram_seq_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .AS_CYC(AS_CYC), .WP_CYC(WP_CYC),
    .HOLD_CYC(HOLD_CYC), .TA_CYC(TA_CYC)
  ) i_fsm (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .cnt_expired(cnt_expired),
    .state(state), .nxt(nxt), .accept(accept), .cnt_load(cnt_load), .cnt_val(cnt_val)
  );

  sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
    .clk(clk), .rst(rst), .state(state), .nxt(nxt), .accept(accept),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  // pulse-width checker: counts low cycles of the write strobe
  logic [CNT_W:0] wlow_cnt;
  always_ff @(posedge clk) begin
    if (rst) wlow_cnt <= '0;
    else if (!mem_we_n) wlow_cnt <= wlow_cnt + 1'b1;
    else wlow_cnt <= '0;
  end

  // R5: strobe low for exactly the computed number of cycles
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> wlow_cnt == (CNT_W+1)'(WP_CYC));
  a_r5_no_overrun: assert property (@(posedge clk) disable iff (rst)
    wlow_cnt <= (CNT_W+1)'(WP_CYC));
  // R9: an accepted request raises busy on the next cycle
  a_r9_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (req && !busy) |=> busy);
endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
  localparam int PER   = 20;
  // 25 ns grade timings; expected counts worked out from the requirements
  localparam int RD_EXP = 2;  // max(ceil(25/20), ceil(25/20), ceil(11/20))
  localparam int WP_EXP = 1;  // max(ceil(20/20), ceil(13/20), ceil(20/20)-0)
  localparam int WR_EXP = 2;  // 0 setup + 1 pulse + hold max(1, ceil(25/20)-1)
  localparam int TA_EXP = 1;

  logic        clk = 0, rst = 1;
  logic        req = 0, req_we = 0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, busy, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #(PER/2) clk = ~clk;

  sram_async_ctrl #(
    .CLK_PERIOD_NS(PER), .T_RC_NS(25), .T_AA_NS(25), .T_OE_NS(11), .T_WC_NS(25),
    .T_AW_NS(20), .T_WP_NS(20), .T_DW_NS(13), .T_AS_NS(0), .T_WR_NS(0),
    .T_DH_NS(0), .TURN_CYC(1)
  ) i_sram_async_ctrl (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // memory model
  logic [7:0] mem [int];
  int         rd_age = 0;
  logic [14:0] age_addr = '0;

  always_comb begin
    mem_dq_in = 8'h3C;
    if (!mem_cs_n && !mem_oe_n && mem_we_n && rd_age >= RD_EXP)
      mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
  end

  // scoreboard and pin monitor
  logic [7:0] exp_q[$];
  int wlow = 0, gap = 0;
  bit have_dir = 0, last_dir = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected rd_valid", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R3 read data", rd_data, e);
        end
      end
      if (mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n)
        check(0, "R8 bus contention", 1, 0);
      if (!mem_we_n && !mem_oe_n) check(0, "R4 oe low in write", 0, 1);
      if (!mem_cs_n && !mem_we_n) begin
        if (!mem_dq_oe) check(0, "R6 data not driven in pulse", 0, 1);
        mem[int'(mem_addr)] = mem_dq_out;
        wlow++;
      end else if (wlow != 0) begin
        check(wlow == WP_EXP, "R5 pulse width", wlow, WP_EXP);
        check(mem_dq_oe == 1'b1, "R6 hold after pulse", mem_dq_oe, 1);
        wlow = 0;
      end
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
        if (mem_addr == age_addr && rd_age > 0) rd_age++;
        else begin rd_age = 1; age_addr = mem_addr; end
      end else rd_age = 0;
      if (!mem_cs_n || mem_dq_oe) begin
        if (mem_cs_n == 1'b0 && gap > 0) begin
          bit dir;
          dir = !mem_we_n || mem_dq_oe;
          if (have_dir && dir != last_dir)
            check(gap >= TA_EXP + 1, "R7 turnaround gap", gap, TA_EXP + 1);
          have_dir = 1; last_dir = dir;
        end
        gap = 0;
      end else gap++;
    end
  end

  // driver
  logic [7:0] shadow [int];
  bit have_prev = 0, prev_we = 0;

  task automatic access(input bit we, input logic [14:0] a, input logic [7:0] d,
                        input bit inject);
    bit turn;
    int n;
    while (busy) @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    if (we) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    turn = have_prev && (prev_we != we);
    have_prev = 1; prev_we = we;
    @(negedge clk);
    req = 0;
    check(busy == 1'b1, "R9 busy after accept", busy, 1);
    n = 0;
    while (busy) begin
      n++;
      if (inject && n == 1) begin
        req = 1; req_we = 1; req_addr = a ^ 15'h0F0F; req_wdata = ~d;
      end
      @(negedge clk);
      req = 0;
    end
    check(n == (we ? WR_EXP : RD_EXP) + (turn ? TA_EXP : 0), "R9 R7 busy length",
          n, (we ? WR_EXP : RD_EXP) + (turn ? TA_EXP : 0));
    check(mem_cs_n && !mem_dq_oe, "R2 standby after access", mem_cs_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rd_valid,
          "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, busy, rd_valid}, 6'b111000);
    rst = 0;
    @(negedge clk);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rd_valid,
          "R1 after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, busy, rd_valid}, 6'b111000);
    // R4 writes of several patterns, back to back (no turnaround)
    access(1, 15'h0000, 8'h00, 0);
    access(1, 15'h7FFF, 8'hFF, 0);
    access(1, 15'h1234, 8'h55, 0);
    access(1, 15'h4AAA, 8'hAA, 0);
    // R3 reads back, first one after a direction change (R7)
    access(0, 15'h7FFF, 8'h00, 0);
    access(0, 15'h0000, 8'h00, 0);
    access(0, 15'h1234, 8'h00, 0);
    access(0, 15'h4AAA, 8'h00, 0);
    access(0, 15'h0100, 8'h00, 0);   // never written: zero
    // alternating directions, each with a turnaround
    for (int i = 0; i < 6; i++) begin
      access(1, 15'(16'h0200 + i), 8'(8'h81 + i * 7), 0);
      access(0, 15'(16'h0200 + i), 8'h00, 0);
    end
    // R9 request while busy is ignored: its address must read unchanged
    access(1, 15'h2222, 8'h96, 1);
    access(0, 15'h2222 ^ 15'h0F0F, 8'h00, 0);
    access(0, 15'h2222, 8'h00, 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    check(mem_cs_n && mem_we_n && !mem_dq_oe && !busy, "R2 idle standby", mem_cs_n, 1);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule